// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block sits between ten interrupt request lines and a CPU core. Each line carries a software-set level bit. That bit either leaves the line at the low level or raises it. Lines 1 and 2 are raised to the topmost level. Lines 3 to 10 are raised to the middle level. A rising edge on a request line marks that line pending. The block then offers the CPU the single best pending line as a fixed vector address, together with a request strobe.

The CPU acknowledges the offered vector. The block then clears that line's pending flag and records the level of the accepted handler on a small in-service stack. A return-from-interrupt pulse removes the most recent entry from the stack. A new request is offered only when it outranks the handler that is currently running. Nesting therefore always climbs in level, and the stack can never hold more than one entry per level.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, or after a reset during operation, no line is pending, the in-service stack is empty and `irq_req` is low.
- R2: A line becomes pending on a low-to-high transition of its `irq_in` bit. It stays pending after the input falls, and only acknowledging it clears it. An input held high does not become pending again once it has been acknowledged.
- R3: With its `lvl_raise` bit at 1, line 1 or line 2 has the top level (X) and lines 3 to 10 have the middle level (H). With its `lvl_raise` bit at 0, any line has the low level (L).
- R4: The vector offered for line n (bit n-1 of `irq_in`) is 0x0003 + 8*(n-1), so line 1 gives 0x0003 and line 10 gives 0x004B.
- R5: Among pending lines, one at a higher level wins over one at a lower level, in the order X above H above L.
- R6: Among pending lines of equal level, the line with the lowest vector address wins.
- R7: `irq_req` is high only when the best pending level is strictly above the level on top of the in-service stack. When the stack is empty, any pending line raises `irq_req`.
- R8: An `ack` while `irq_req` is high clears the offered line and pushes its level. An `ack` while `irq_req` is low changes nothing.
- R9: A `reti` pops the top of the in-service stack. A `reti` on an empty stack changes nothing.
- R10: When an accepted `ack` and a `reti` arrive in the same cycle, the push takes effect and the `reti` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 10 | Request lines; bit n-1 is line n |
| lvl_raise | input | 10 | Per-line level bit: 1 raises the line, 0 leaves it low |
| ack | input | 1 | CPU accepts the offered vector |
| reti | input | 1 | Return from the running handler |
| irq_req | output | 1 | A pending line outranks the running handler |
| irq_vec | output | 16 | Vector address of the winning line |

## Verification
The bench aims at the nesting boundaries:
- A request at the same level as the running handler must stay held off. A design that compared with greater-or-equal would re-enter a handler of the same level.
- An acknowledge offered while the strobe is low, a return on an empty stack, and an acknowledge and a return in the same cycle must each leave the stack exactly as stated. A design that mishandled any of them would release a held request too early or hold it too long. The bench makes this visible through `irq_req`.
- Priority ties and cross-level contests are checked through the vector address. A wrong scan order, or a wrong mapping of the raise bit on lines 1 and 2 against lines 3 to 10, would show up as the wrong vector.
- An input held high after its acknowledge is checked, to catch a design that latches on level instead of on edge.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  // Ordered so that a numeric compare gives the priority order
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } lvl_e;
endpackage

// File: rtl/irqarb_level_map.sv
module irqarb_level_map
  import irqarb_pkg::*;
#(
  parameter int unsigned NUM_LINES = 10,
  parameter logic [NUM_LINES-1:0] TOP_MASK = NUM_LINES'(2'b11)
) (
  input  logic [NUM_LINES-1:0]      raise_i,
  output logic [NUM_LINES-1:0][1:0] lvl_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    if (TOP_MASK[g]) begin : g_top
      assign lvl_o[g] = raise_i[g] ? LVL_TOP : LVL_LOW;
    end else begin : g_mid
      assign lvl_o[g] = raise_i[g] ? LVL_HIGH : LVL_LOW;
    end
  end
endmodule

// File: rtl/irqarb_picker.sv
module irqarb_picker
  import irqarb_pkg::*;
#(
  parameter int unsigned NUM_LINES = 10,
  parameter int unsigned IDX_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]      pend_i,
  input  logic [NUM_LINES-1:0][1:0] lvl_i,
  output logic                      any_o,
  output logic [1:0]                best_lvl_o,
  output logic [IDX_W-1:0]          win_idx_o
);
  logic [1:0]       best;
  logic [IDX_W-1:0] idx;

  // Downward scan with >= lets a lower index take over a tie
  always_comb begin
    best = LVL_NONE;
    idx  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend_i[i] && (lvl_i[i] >= best)) begin
        best = lvl_i[i];
        idx  = IDX_W'(i);
      end
    end
  end

  assign any_o      = |pend_i;
  assign best_lvl_o = best;
  assign win_idx_o  = idx;
endmodule

// File: rtl/irqarb_stack.sv
module irqarb_stack
  import irqarb_pkg::*;
#(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [1:0]       push_lvl_i,
  input  logic             pop_i,
  output logic [1:0]       top_lvl_o,
  output logic [CNT_W-1:0] depth_o
);
  logic [DEPTH-1:0][1:0] stk_q, stk_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  stk_en;

  always_comb begin
    stk_d = stk_q;
    cnt_d = cnt_q;
    if (push_i && (cnt_q < CNT_W'(DEPTH))) begin
      stk_d[cnt_q] = push_lvl_i;
      cnt_d        = cnt_q + 1'b1;
    end else if (pop_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign stk_en = push_i || pop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q <= '0;
      cnt_q <= '0;
    end else if (stk_en) begin
      stk_q <= stk_d;
      cnt_q <= cnt_d;
    end
  end

  assign top_lvl_o = (cnt_q == '0) ? LVL_NONE : stk_q[cnt_q - 1'b1];
  assign depth_o   = cnt_q;
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irqarb_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 10,
  parameter int unsigned STACK_DEPTH = 3,
  parameter int unsigned VEC_W       = 16,
  parameter int unsigned VEC_BASE    = 3,
  parameter int unsigned VEC_STRIDE  = 8,
  parameter logic [NUM_LINES-1:0] TOP_MASK = NUM_LINES'(2'b11)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] lvl_raise,
  input  logic                 ack,
  input  logic                 reti,
  output logic                 irq_req,
  output logic [VEC_W-1:0]     irq_vec
);
  localparam int unsigned IDX_W = $clog2(NUM_LINES);
  localparam int unsigned CNT_W = $clog2(STACK_DEPTH + 1);
  localparam logic [VEC_W-1:0] BASE_V   = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] STRIDE_V = VEC_W'(VEC_STRIDE);

  logic [NUM_LINES-1:0]      in_prev_q;
  logic [NUM_LINES-1:0]      pend_q, pend_d;
  logic [NUM_LINES-1:0]      rise, clr;
  logic [NUM_LINES-1:0][1:0] line_lvl;
  logic                      any_pend;
  logic [1:0]                best_lvl, top_lvl;
  logic [IDX_W-1:0]          win_idx;
  logic [CNT_W-1:0]          depth;
  logic                      accept, pop;

  irqarb_level_map #(.NUM_LINES(NUM_LINES), .TOP_MASK(TOP_MASK)) u_map (
    .raise_i (lvl_raise),
    .lvl_o   (line_lvl)
  );

  irqarb_picker #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick (
    .pend_i     (pend_q),
    .lvl_i      (line_lvl),
    .any_o      (any_pend),
    .best_lvl_o (best_lvl),
    .win_idx_o  (win_idx)
  );

  irqarb_stack #(.DEPTH(STACK_DEPTH), .CNT_W(CNT_W)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (accept),
    .push_lvl_i (best_lvl),
    .pop_i      (pop),
    .top_lvl_o  (top_lvl),
    .depth_o    (depth)
  );

  assign irq_req = any_pend && (best_lvl > top_lvl);
  assign irq_vec = BASE_V + STRIDE_V * VEC_W'(win_idx);
  assign accept  = ack && irq_req;
  assign pop     = reti && !accept;

  // Next-state logic: a fresh edge wins over a clear in the same cycle
  always_comb begin
    rise   = irq_in & ~in_prev_q;
    clr    = '0;
    if (accept) clr[win_idx] = 1'b1;
    pend_d = (pend_q & ~clr) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_prev_q <= '0;
      pend_q    <= '0;
    end else begin
      in_prev_q <= irq_in;
      pend_q    <= pend_d;
    end
  end
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int unsigned CNT_W       = 2,
  parameter int unsigned STACK_DEPTH = 3,
  parameter int unsigned VEC_W       = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             reti,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [1:0]       best_lvl,
  input logic [1:0]       top_lvl,
  input logic [CNT_W-1:0] depth
);
  // R8
  stack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> (depth == $past(depth) + 1'b1));

  // R9
  stack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(ack && irq_req) && (depth != '0)) |=> (depth == $past(depth) - 1'b1));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && (depth == '0)) |=> (depth == '0));

  // R7
  req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (best_lvl > top_lvl));

  // R4
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'b011));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(STACK_DEPTH));
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
  .CNT_W(CNT_W), .STACK_DEPTH(STACK_DEPTH), .VEC_W(VEC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .reti     (reti),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .best_lvl (best_lvl),
  .top_lvl  (top_lvl),
  .depth    (depth)
);

// File: tb/irq_prio_arbiter_tb.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  irq_in;
  logic [9:0]  lvl_raise;
  logic        ack;
  logic        reti;
  logic        irq_req;
  logic [15:0] irq_vec;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_prio_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl_raise(lvl_raise),
    .ack(ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // {pattern, raise, expected first vector}
  localparam logic [35:0] TBL [8] = '{
    {10'b0000000001, 10'b0000000000, 16'h0003},  // R4 line 1
    {10'b1000000000, 10'b0000000000, 16'h004B},  // R4 line 10
    {10'b0000000110, 10'b0000000000, 16'h000B},  // R6 tie at L
    {10'b0000000101, 10'b0000000100, 16'h0013},  // R5 H over L
    {10'b0000000101, 10'b0000000101, 16'h0003},  // R3 X over H
    {10'b1100000000, 10'b1000000000, 16'h004B},  // R3 H on line 10
    {10'b0000110010, 10'b0000110000, 16'h0023},  // R6 tie at H
    {10'b0100000010, 10'b0100000010, 16'h000B}   // R5 X over H
  };

  task automatic chk(input string tag, input logic exp_req,
                     input logic [15:0] exp_vec, input bit use_vec);
    #1;
    n_run++;
    if (irq_req !== exp_req || (use_vec && irq_vec !== exp_vec)) begin
      n_fail++;
      $display("FAIL %s: req=%0b vec=%h expected req=%0b vec=%h",
               tag, irq_req, irq_vec, exp_req, exp_vec);
    end
  endtask

  task automatic pulse(input logic [9:0] pat);
    irq_in = pat;
    @(negedge clk);
    irq_in = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic drain();
    for (int g = 0; g < 12 && irq_req; g++) begin
      do_ack();
      do_reti();
      #1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    irq_in = '0; lvl_raise = '0; ack = 1'b0; reti = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    chk("R1 reset idle", 1'b0, 16'h0, 1'b0);

    for (int k = 0; k < 8; k++) begin
      lvl_raise = TBL[k][25:16];
      pulse(TBL[k][35:26]);
      chk("R3/R4/R5/R6 table winner", 1'b1, TBL[k][15:0], 1'b1);
      drain();
      chk("R8 table drained", 1'b0, 16'h0, 1'b0);
    end

    // R1: reset during operation clears pending
    lvl_raise = '0;
    pulse(10'b0000010000);
    do_reset();
    chk("R1 reset clears pending", 1'b0, 16'h0, 1'b0);

    // R7 nesting
    pulse(10'b0000000001);
    chk("R7 empty stack accepts L", 1'b1, 16'h0003, 1'b1);
    do_ack();
    pulse(10'b0000000100);
    chk("R7 equal level held off", 1'b0, 16'h0, 1'b0);
    lvl_raise = 10'b0000001010;
    pulse(10'b0000001000);
    chk("R7 H over running L", 1'b1, 16'h001B, 1'b1);
    do_ack();
    pulse(10'b0000000010);
    chk("R3 X over running H", 1'b1, 16'h000B, 1'b1);
    do_ack();
    chk("R7 full nest holds L", 1'b0, 16'h0, 1'b0);
    do_reti();
    chk("R9 pop to H", 1'b0, 16'h0, 1'b0);
    do_reti();
    chk("R9 pop to L", 1'b0, 16'h0, 1'b0);
    do_reti();
    chk("R9 pop to empty", 1'b1, 16'h0013, 1'b1);

    // R8 ack while strobe low
    do_ack();
    pulse(10'b0000001000);
    do_ack();
    pulse(10'b0000010000);
    chk("R7 L under H held", 1'b0, 16'h0, 1'b0);
    do_ack();
    do_reti();
    chk("R8 ignored ack kept stack", 1'b0, 16'h0, 1'b0);
    do_reti();
    chk("R8 ignored ack kept pending", 1'b1, 16'h0023, 1'b1);

    // R9 reti on empty
    do_ack();
    do_reti();
    do_reti();
    pulse(10'b0000100000);
    chk("R9 after empty pop", 1'b1, 16'h002B, 1'b1);
    do_ack();
    pulse(10'b0001000000);
    chk("R9 stack intact after empty pop", 1'b0, 16'h0, 1'b0);

    // R10 ack and reti together
    pulse(10'b0000001000);
    chk("R10 H offered", 1'b1, 16'h001B, 1'b1);
    ack = 1'b1; reti = 1'b1;
    @(negedge clk);
    ack = 1'b0; reti = 1'b0;
    chk("R10 push kept", 1'b0, 16'h0, 1'b0);
    do_reti();
    chk("R10 reti ignored, L still running", 1'b0, 16'h0, 1'b0);
    do_reti();
    chk("R10 final release", 1'b1, 16'h0033, 1'b1);
    drain();

    // R2 held input
    irq_in = 10'b0010000000;
    @(negedge clk);
    chk("R2 edge latched", 1'b1, 16'h003B, 1'b1);
    do_ack();
    do_reti();
    repeat (3) @(negedge clk);
    chk("R2 held high no relatch", 1'b0, 16'h0, 1'b0);
    irq_in = '0;
    repeat (2) @(negedge clk);
    chk("R2 falling edge no request", 1'b0, 16'h0, 1'b0);
    pulse(10'b0010000000);
    repeat (3) @(negedge clk);
    chk("R2 pending after input low", 1'b1, 16'h003B, 1'b1);
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule